// File: doc/BRIEF.md
# Local Interrupt Acceptance and Priority Unit

This unit sits beside one processor core and decides which interrupt vector the core is offered next. Vectors arrive one at a time on a request port and are latched into a 256-entry pending vector. The unit keeps a second 256-entry vector of interrupts that the core has taken but not yet retired. It presents the best pending vector to the core only when three conditions hold: software has switched the unit on, the vector's priority class beats the task priority threshold, and it beats the highest interrupt already being serviced.

Software reaches the unit through a 32-bit register port with one-cycle read latency. It sets the task priority, switches delivery on and off, retires interrupts by writing the end-of-interrupt register, and inspects the pending, in-service and trigger-mode vectors. These are exposed as eight 32-bit words spaced 16 bytes apart. Illegal request vectors are recorded in an error register that software latches with a write and then reads.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset the task priority reads 0x00, the spurious register reads 0x0FF (delivery off), all three vector banks read zero, and int_valid is 0.
- R2: Register offsets are task priority 0x080, arbitration priority 0x090, processor priority 0x0A0, end-of-interrupt 0x0B0, spurious 0x0F0, error 0x280, and banks at 0x100 (in-service), 0x180 (trigger mode) and 0x200 (pending). Vector v lives in the word at bank base + (v/32)*16, bit v%32. Read data appears the cycle after bus_rd, and writes to bank words are ignored.
- R3: A request with a vector of 16 or above sets that vector's pending bit and stores req_level in its trigger-mode bit. A request below 16 is not latched and instead sets error bit 0.
- R4: Priority class is vector bits [7:4]. The highest-numbered pending vector is offered on int_valid/int_vector, one cycle after the state allows it, if its class is above the task priority class and above the class of the highest in-service vector (class 0 when none is in service).
- R5: Task priority 0xFF blocks every vector, task priority 0x00 lets every legal vector through, and intermediate values block classes at or below their upper nibble.
- R6: When int_ack is high while int_valid is high, the offered vector's pending bit clears and its in-service bit sets on that edge, and int_valid is 0 in the next cycle.
- R7: A write of any data to the end-of-interrupt register clears only the highest-numbered in-service bit. With nothing in service, the write changes nothing.
- R8: Spurious register bit 8 enables delivery, bit 9 is a stored focus-disable flag, and bits [7:0] hold the spurious vector. All ten bits read back. While bit 8 is 0 nothing is offered and requests stay pending.
- R9: Processor priority (also returned at the arbitration offset) reads the task priority when its class is at least the highest in-service class, and otherwise reads that in-service class shifted into bits [7:4] with zeros below.
- R10: A write to the error register copies the accumulated errors into the readable value and clears the accumulation, so a write followed by a read returns the errors seen since the previous write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| req_valid | input | 1 | Incoming interrupt request strobe |
| req_vector | input | 8 | Requested vector number |
| req_level | input | 1 | Trigger mode of the request (1 = level) |
| int_valid | output | 1 | A vector is offered to the core |
| int_vector | output | 8 | Offered vector |
| int_ack | input | 1 | Core accepts the offered vector |

## Verification
The bench builds the unit with its default 256 vectors, 32-bit data and 12-bit offsets. This gives eight words per bank and all sixteen priority classes. Vectors can therefore be placed in different words (for example 0x31, 0x52 and 0xE0) and in both the lowest and the highest class. The threshold cases at task priority 0x00, 0xD0 and 0xFF are covered, along with the illegal range below 16.

// File: rtl/iau_pkg.sv
package iau_pkg;
  localparam logic [11:0] OFS_TPR = 12'h080;
  localparam logic [11:0] OFS_APR = 12'h090;
  localparam logic [11:0] OFS_PPR = 12'h0A0;
  localparam logic [11:0] OFS_EOI = 12'h0B0;
  localparam logic [11:0] OFS_SVR = 12'h0F0;
  localparam logic [11:0] OFS_ISR = 12'h100;
  localparam logic [11:0] OFS_TMR = 12'h180;
  localparam logic [11:0] OFS_IRR = 12'h200;
  localparam logic [11:0] OFS_ESR = 12'h280;
  localparam int ERR_ILLEGAL_BIT = 0;
  localparam int CLS_W = 4;
endpackage

// File: rtl/iau_msb_find.sv
module iau_msb_find #(
  parameter int W  = 256,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  bits,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |bits;
    idx = '0;
    for (int i = 0; i < W; i++)
      if (bits[i]) idx = IW'(i);
  end
endmodule

// File: rtl/iau_prio_gate.sv
module iau_prio_gate #(
  parameter int VW = 8
) (
  input  logic          enable,
  input  logic          pend_any,
  input  logic [VW-1:0] pend_vec,
  input  logic          svc_any,
  input  logic [VW-1:0] svc_vec,
  input  logic [VW-1:0] tpr,
  output logic          deliver,
  output logic [VW-1:0] ppr
);
  import iau_pkg::*;
  logic [CLS_W-1:0] pend_cls, svc_cls, tpr_cls;

  always_comb begin
    pend_cls = pend_vec[VW-1 -: CLS_W];
    tpr_cls  = tpr[VW-1 -: CLS_W];
    svc_cls  = svc_any ? svc_vec[VW-1 -: CLS_W] : '0;
    deliver  = enable && pend_any && (pend_cls > tpr_cls) && (pend_cls > svc_cls);
    ppr      = (tpr_cls >= svc_cls) ? tpr : {svc_cls, {(VW-CLS_W){1'b0}}};
  end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit #(
  parameter int NVEC    = 256,
  parameter int DW      = 32,
  parameter int AW      = 12,
  parameter int MIN_VEC = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [AW-1:0]            bus_addr,
  input  logic [DW-1:0]            bus_wdata,
  output logic [DW-1:0]            bus_rdata,
  input  logic                     req_valid,
  input  logic [$clog2(NVEC)-1:0]  req_vector,
  input  logic                     req_level,
  output logic                     int_valid,
  output logic [$clog2(NVEC)-1:0]  int_vector,
  input  logic                     int_ack
);
  import iau_pkg::*;
  localparam int VW    = $clog2(NVEC);
  localparam int NWORD = NVEC / DW;
  localparam int SVR_W = 10;
  localparam int ERR_W = 8;
  localparam int BSEL  = AW - 7;

  logic [VW-1:0]    tpr;
  logic [SVR_W-1:0] svr;
  logic [NVEC-1:0]  irr, isr, tmr, irr_n, isr_n;
  logic [ERR_W-1:0] err_acc, err_vis;
  logic             sw_en;

  logic          pend_any, svc_any, deliver, ack_fire, req_ok;
  logic [VW-1:0] pend_idx, svc_idx, ppr;
  logic          wr_tpr, wr_eoi, wr_svr, wr_err;

  assign sw_en    = svr[8];
  assign ack_fire = int_valid && int_ack;
  assign req_ok   = req_valid && (int'(req_vector) >= MIN_VEC);
  assign wr_tpr   = bus_wr && (bus_addr == AW'(OFS_TPR));
  assign wr_eoi   = bus_wr && (bus_addr == AW'(OFS_EOI));
  assign wr_svr   = bus_wr && (bus_addr == AW'(OFS_SVR));
  assign wr_err   = bus_wr && (bus_addr == AW'(OFS_ESR));

  iau_msb_find #(.W(NVEC), .IW(VW)) u_pend_find (.bits(irr), .any(pend_any), .idx(pend_idx));
  iau_msb_find #(.W(NVEC), .IW(VW)) u_svc_find  (.bits(isr), .any(svc_any),  .idx(svc_idx));

  iau_prio_gate #(.VW(VW)) u_gate (
    .enable(sw_en), .pend_any(pend_any), .pend_vec(pend_idx),
    .svc_any(svc_any), .svc_vec(svc_idx), .tpr(tpr),
    .deliver(deliver), .ppr(ppr)
  );

  always_comb begin
    irr_n = irr;
    isr_n = isr;
    if (ack_fire) irr_n[int_vector] = 1'b0;
    if (req_ok) irr_n[req_vector] = 1'b1;
    if (wr_eoi && svc_any) isr_n[svc_idx] = 1'b0;
    if (ack_fire) isr_n[int_vector] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr        <= '0;
      isr        <= '0;
      tmr        <= '0;
      tpr        <= '0;
      svr        <= SVR_W'(10'h0FF);
      err_acc    <= '0;
      err_vis    <= '0;
      int_valid  <= 1'b0;
      int_vector <= '0;
    end else begin
      irr <= irr_n;
      isr <= isr_n;
      if (req_ok) tmr[req_vector] <= req_level;
      if (wr_tpr) tpr <= bus_wdata[VW-1:0];
      if (wr_svr) svr <= bus_wdata[SVR_W-1:0];
      err_acc <= (wr_err ? '0 : err_acc) |
                 (ERR_W'(req_valid && !req_ok) << ERR_ILLEGAL_BIT);
      if (wr_err) err_vis <= err_acc;
      int_valid  <= deliver && !ack_fire;
      int_vector <= pend_idx;
    end
  end

  logic [DW-1:0] irr_w [NWORD];
  logic [DW-1:0] isr_w [NWORD];
  logic [DW-1:0] tmr_w [NWORD];
  for (genvar g = 0; g < NWORD; g++) begin : g_word
    assign irr_w[g] = irr[g*DW +: DW];
    assign isr_w[g] = isr[g*DW +: DW];
    assign tmr_w[g] = tmr[g*DW +: DW];
  end

  logic [DW-1:0] rd_word;
  logic [2:0]    widx;
  logic [BSEL-1:0] bank;
  logic          widx_ok;

  always_comb begin
    widx    = bus_addr[6:4];
    bank    = bus_addr[AW-1:7];
    widx_ok = int'(widx) < NWORD;
    rd_word = '0;
    if (bus_addr == AW'(OFS_TPR)) rd_word = DW'(tpr);
    else if (bus_addr == AW'(OFS_APR) || bus_addr == AW'(OFS_PPR)) rd_word = DW'(ppr);
    else if (bus_addr == AW'(OFS_SVR)) rd_word = DW'(svr);
    else if (bus_addr == AW'(OFS_ESR)) rd_word = DW'(err_vis);
    else if (widx_ok && bank == BSEL'(OFS_ISR >> 7)) rd_word = isr_w[widx];
    else if (widx_ok && bank == BSEL'(OFS_TMR >> 7)) rd_word = tmr_w[widx];
    else if (widx_ok && bank == BSEL'(OFS_IRR >> 7)) rd_word = irr_w[widx];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int NVEC = 256,
  parameter int VW   = $clog2(NVEC)
) (
  input logic            clk,
  input logic            rst,
  input logic            sw_en,
  input logic [VW-1:0]   tpr,
  input logic            int_valid,
  input logic [VW-1:0]   int_vector,
  input logic            int_ack,
  input logic            req_valid,
  input logic [VW-1:0]   req_vector,
  input logic            wr_eoi,
  input logic [NVEC-1:0] irr,
  input logic [NVEC-1:0] isr,
  input logic            svc_any,
  input logic [VW-1:0]   svc_idx
);
  AST_OFF_NO_DELIVERY: assert property (@(posedge clk) disable iff (rst)
    int_valid |-> $past(sw_en)); // R8

  AST_ABOVE_THRESHOLD: assert property (@(posedge clk) disable iff (rst)
    int_valid |-> (int_vector[VW-1 -: 4] > $past(tpr[VW-1 -: 4]))); // R5

  AST_ABOVE_SERVICE: assert property (@(posedge clk) disable iff (rst)
    int_valid |-> (int_vector[VW-1 -: 4] > $past(svc_any ? svc_idx[VW-1 -: 4] : 4'h0))); // R4

  AST_ACK_MOVES_BIT: assert property (@(posedge clk) disable iff (rst)
    (int_valid && int_ack && !(req_valid && req_vector == int_vector))
      |=> (isr[$past(int_vector)] && !irr[$past(int_vector)] && !int_valid)); // R6

  AST_EMPTY_EOI_NOOP: assert property (@(posedge clk) disable iff (rst)
    (wr_eoi && isr == '0 && !(int_valid && int_ack)) |=> (isr == '0)); // R7
endmodule

bind irq_accept_unit irq_accept_chk #(.NVEC(NVEC), .VW($clog2(NVEC))) u_chk (
  .clk(clk), .rst(rst), .sw_en(sw_en), .tpr(tpr),
  .int_valid(int_valid), .int_vector(int_vector), .int_ack(int_ack),
  .req_valid(req_valid), .req_vector(req_vector), .wr_eoi(wr_eoi),
  .irr(irr), .isr(isr), .svc_any(svc_any), .svc_idx(svc_idx)
);

// File: tb/tb_irq_accept_unit.sv
`timescale 1ns/1ps
module tb_irq_accept_unit;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_REQ = 3'd2, OP_INT = 3'd3;

  typedef struct packed {
    logic [2:0]  op;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  rq;
  } step_t;

  localparam int NSTEP = 54;
  localparam step_t TBL [NSTEP] = '{
    '{OP_WR,  12'h0F0, 32'h1FF, 32'h0, 4'd8},         // R8 enable
    '{OP_RD,  12'h0F0, 32'h0, 32'h1FF, 4'd8},         // R8
    '{OP_REQ, 12'h000, 32'h031, 32'h0, 4'd3},         // R3
    '{OP_INT, 12'h000, 32'h1, 32'h131, 4'd4},         // R4 offer 0x31
    '{OP_RD,  12'h110, 32'h0, 32'h00020000, 4'd2},    // R2 isr word1 bit17
    '{OP_RD,  12'h210, 32'h0, 32'h0, 4'd6},           // R6 pending cleared
    '{OP_RD,  12'h0A0, 32'h0, 32'h30, 4'd9},          // R9
    '{OP_REQ, 12'h000, 32'h035, 32'h0, 4'd4},
    '{OP_INT, 12'h000, 32'h0, 32'h0, 4'd4},           // R4 same class blocked
    '{OP_REQ, 12'h000, 32'h152, 32'h0, 4'd3},         // R3 level request
    '{OP_INT, 12'h000, 32'h1, 32'h152, 4'd4},
    '{OP_RD,  12'h1A0, 32'h0, 32'h00040000, 4'd3},    // R3 trigger bit
    '{OP_WR,  12'h0B0, 32'hDEAD, 32'h0, 4'd7},        // R7 retire 0x52
    '{OP_INT, 12'h000, 32'h0, 32'h0, 4'd7},
    '{OP_RD,  12'h120, 32'h0, 32'h0, 4'd7},
    '{OP_RD,  12'h110, 32'h0, 32'h00020000, 4'd7},    // R7 only highest cleared
    '{OP_WR,  12'h0B0, 32'h0, 32'h0, 4'd7},
    '{OP_INT, 12'h000, 32'h1, 32'h135, 4'd7},
    '{OP_WR,  12'h0B0, 32'h0, 32'h0, 4'd7},
    '{OP_WR,  12'h080, 32'hFF, 32'h0, 4'd5},          // R5 block all
    '{OP_REQ, 12'h000, 32'h0E0, 32'h0, 4'd5},
    '{OP_INT, 12'h000, 32'h0, 32'h0, 4'd5},
    '{OP_RD,  12'h270, 32'h0, 32'h1, 4'd5},
    '{OP_WR,  12'h080, 32'hD0, 32'h0, 4'd5},
    '{OP_INT, 12'h000, 32'h1, 32'h1E0, 4'd5},         // R5 class 14 over 13
    '{OP_RD,  12'h0A0, 32'h0, 32'hE0, 4'd9},
    '{OP_RD,  12'h090, 32'h0, 32'hE0, 4'd9},
    '{OP_WR,  12'h0B0, 32'h0, 32'h0, 4'd7},
    '{OP_WR,  12'h0F0, 32'h0FF, 32'h0, 4'd8},         // R8 disable
    '{OP_REQ, 12'h000, 32'h040, 32'h0, 4'd8},
    '{OP_INT, 12'h000, 32'h0, 32'h0, 4'd8},
    '{OP_RD,  12'h220, 32'h0, 32'h1, 4'd8},           // R8 held
    '{OP_WR,  12'h080, 32'h0, 32'h0, 4'd5},
    '{OP_WR,  12'h0F0, 32'h1FF, 32'h0, 4'd8},
    '{OP_INT, 12'h000, 32'h1, 32'h140, 4'd8},
    '{OP_WR,  12'h0B0, 32'h0, 32'h0, 4'd7},
    '{OP_WR,  12'h0B0, 32'h0, 32'h0, 4'd7},           // R7 empty retire
    '{OP_RD,  12'h120, 32'h0, 32'h0, 4'd7},
    '{OP_RD,  12'h0A0, 32'h0, 32'h0, 4'd7},
    '{OP_REQ, 12'h000, 32'h061, 32'h0, 4'd4},
    '{OP_REQ, 12'h000, 32'h09F, 32'h0, 4'd4},
    '{OP_INT, 12'h000, 32'h1, 32'h19F, 4'd4},         // R4 highest first
    '{OP_RD,  12'h0A0, 32'h0, 32'h90, 4'd9},
    '{OP_WR,  12'h0B0, 32'h0, 32'h0, 4'd7},
    '{OP_INT, 12'h000, 32'h1, 32'h161, 4'd4},
    '{OP_WR,  12'h0B0, 32'h0, 32'h0, 4'd7},
    '{OP_REQ, 12'h000, 32'h005, 32'h0, 4'd3},         // R3 illegal
    '{OP_RD,  12'h200, 32'h0, 32'h0, 4'd3},
    '{OP_RD,  12'h280, 32'h0, 32'h0, 4'd10},          // R10 not yet latched
    '{OP_WR,  12'h280, 32'h0, 32'h0, 4'd10},
    '{OP_RD,  12'h280, 32'h0, 32'h1, 4'd10},
    '{OP_WR,  12'h280, 32'h0, 32'h0, 4'd10},
    '{OP_RD,  12'h280, 32'h0, 32'h0, 4'd10},
    '{OP_WR,  12'h0F0, 32'h3AB, 32'h0, 4'd8}
  };

  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0, req_valid = 0, req_level = 0, int_ack = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0]  req_vector = '0, int_vector;
  logic        int_valid;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  irq_accept_unit dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
    .req_vector(req_vector), .req_level(req_level), .int_valid(int_valid),
    .int_vector(int_vector), .int_ack(int_ack)
  );

  task automatic check(input int rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input int rq);
    bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
    check(rq, bus_rdata, exp);
  endtask

  task automatic req(input logic [8:0] d);
    req_valid = 1; req_vector = d[7:0]; req_level = d[8];
    @(negedge clk); req_valid = 0;
  endtask

  task automatic offer(input logic ack, input logic [31:0] exp, input int rq);
    @(negedge clk);
    check(rq, {23'b0, int_valid, int_valid ? int_vector : 8'h00}, exp);
    if (ack && int_valid) begin
      int_ack = 1; @(negedge clk); int_ack = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check(1, {31'b0, int_valid}, 32'h0);
    rd(12'h080, 32'h0, 1);
    rd(12'h0F0, 32'h0FF, 1);
    rd(12'h200, 32'h0, 1);
    rd(12'h170, 32'h0, 1);
    // R2 bank words ignore writes
    wr(12'h110, 32'hFFFFFFFF);
    rd(12'h110, 32'h0, 2);
    for (int i = 0; i < NSTEP; i++) begin
      case (TBL[i].op)
        OP_WR:   wr(TBL[i].addr, TBL[i].data);
        OP_RD:   rd(TBL[i].addr, TBL[i].exp, int'(TBL[i].rq));
        OP_REQ:  req(TBL[i].data[8:0]);
        default: offer(TBL[i].data[0], TBL[i].exp, int'(TBL[i].rq));
      endcase
    end
    rd(12'h0F0, 32'h3AB, 8); // R8 focus and vector bits read back
    // R6 offer drops the cycle after ack
    req(9'h0A7);
    @(negedge clk);
    check(4, {31'b0, int_valid}, 32'h1);
    int_ack = 1; @(negedge clk); int_ack = 0;
    check(6, {31'b0, int_valid}, 32'h0);
    rd(12'h150, 32'h00000080, 6);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule